// File: doc/BRIEF.md
# Multiplexed NOR Flash Bus Controller

This block connects an on-chip request port to an external 16-bit NOR Flash or PSRAM device that shares its low address bits and its data on one bidirectional bus. A request names a direction, a 26-bit word address, write data, one of four banks, a burst length and whether it is a synchronous burst read. The controller then drives the chip selects, the address-valid strobe, output enable, write enable and the upper address pins. It returns one response per captured word.

Single accesses run asynchronously with programmable address and data phase lengths. Synchronous burst reads run a divided memory clock, count a programmable latency and then take one word per memory clock. A wait input from the device holds off capture. After every access a programmable turnaround gap keeps the bus idle before the next request is taken. The shared bus is presented as separate output, output-enable and input vectors, so the pad cell can sit outside the block.

Top module: `mnb_ctrl`

## Requirements
- R1: After reset all chip selects, output enable, write enable and the address-valid strobe are high (inactive), the bus output enable and the memory clock are low, `req_ready` is high and `rsp_valid` is low.
- R2: An asynchronous read keeps the address-valid strobe low and drives `addr[15:0]` on the shared bus for `cfg_aset`+1 cycles after acceptance. It then releases the bus and holds output enable low for at least `cfg_dset`+1 cycles. It captures `mem_ad_i` in the last cycle of that phase and presents it on `rsp_data` the following cycle with `rsp_valid` and `rsp_last` high.
- R3: An asynchronous write holds write enable low for the data phase and drives the write data on the bus only while write enable is low. It drives the low address only while the address-valid strobe is low. Output enable and write enable are never low together. The write response carries `rsp_data` = 0.
- R4: While `mem_wait_n` is low at a capture point, no word is taken: the asynchronous data phase is stretched, and a synchronous capture moves to the next memory clock period.
- R5: Only chip select bit `req_bank` (bit 0 = bank 0) goes low, from acceptance up to and including the final capture cycle.
- R6: During a synchronous burst the memory clock has a period of P = max(`cfg_div`+1, 2) system cycles. It is high for the first floor(P/2) cycles of each period, and its first period starts in the cycle after acceptance. It is low at all other times.
- R7: A synchronous burst drives the address for one memory clock period (period 0). Word k is captured in the last system cycle of period `cfg_lat`+2+k.
- R8: A synchronous burst returns `req_len`+1 words, with `rsp_last` high only on the final one.
- R9: After the final capture, all chip selects stay high for `cfg_turn`+1 cycles. `req_ready` rises in the cycle after that.
- R10: Timing inputs are sampled when a request is accepted. Changing them during an access does not alter it.
- R11: A request with both the write and synchronous flags set runs as an asynchronous write.
- R12: `req_ready` is high only when the controller is idle. A request held on the port while busy starts no access and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sync | input | 1 | 1 = synchronous burst read |
| req_addr | input | 26 | Word address |
| req_wdata | input | 16 | Write data |
| req_bank | input | 2 | Bank select |
| req_len | input | 4 | Burst words minus one |
| cfg_div | input | 4 | Memory clock period minus one |
| cfg_lat | input | 4 | Burst latency minus two |
| cfg_turn | input | 4 | Turnaround cycles minus one |
| cfg_aset | input | 4 | Async address phase cycles minus one |
| cfg_dset | input | 4 | Async data phase cycles minus one |
| rsp_valid | output | 1 | Response word valid |
| rsp_last | output | 1 | Final word of the access |
| rsp_data | output | 16 | Captured read data |
| mem_clk | output | 1 | Divided memory clock |
| mem_ce_n | output | 4 | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_adv_n | output | 1 | Active-low address-valid strobe |
| mem_addr_hi | output | 10 | Address bits 25:16 |
| mem_ad_o | output | 16 | Shared bus output value |
| mem_ad_oe | output | 1 | Shared bus drive enable |
| mem_ad_i | input | 16 | Shared bus input value |
| mem_wait_n | input | 1 | Active-low wait from the device |

## Verification
The bench drives the bus input with a value that encodes the current cycle number, so each captured word shows exactly which cycle it was sampled in. This tells a latency or phase-length error apart from a data-path error. Asynchronous reads and writes are swept over every small address and data phase length. Synchronous bursts are swept over divider, latency and length, which separates the clamped divide-by-one case and the odd divide ratios from the even ones. Wait windows placed over capture points, timing changes made mid-access, held requests while busy, and every bank then isolate the stall, sampling, acceptance and select decoding.

// File: rtl/mnb_pkg.sv
// Shared types for the multiplexed NOR bus controller.
// Assumes all timing fields share one width.
package mnb_pkg;
    localparam int CFG_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_AADDR,
        ST_ADATA,
        ST_SADDR,
        ST_SLAT,
        ST_SDATA,
        ST_TURN
    } mnb_state_e;

    typedef struct packed {
        logic [CFG_W-1:0] div;
        logic [CFG_W-1:0] lat;
        logic [CFG_W-1:0] turn;
        logic [CFG_W-1:0] aset;
        logic [CFG_W-1:0] dset;
    } mnb_timing_t;
endpackage

// File: rtl/mnb_mclk.sv
// Memory clock divider. Counts system cycles while run is high. It raises the
// clock at the start of each period and flags the last cycle of the period.
// Assumes period_m1 >= 1 and stays constant while run is high.
module mnb_mclk #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] period_m1,
    output logic          mclk,
    output logic          cyc_last
);
    logic [CW-1:0] cnt;
    logic [CW:0]   half;

    // Position counter inside the current memory clock period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == period_m1) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // High phase covers the first floor(P/2) cycles of each period.
    always_comb begin
        half     = ({1'b0, period_m1} + 1'b1) >> 1;
        mclk     = run && ({1'b0, cnt} < half);
        cyc_last = run && (cnt == period_m1);
    end

    a_r6_rise_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mclk) |-> (cnt == '0));
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= period_m1));
endmodule

// File: rtl/mnb_fsm.sv
// Access sequencer. Accepts one request when idle and latches its fields and
// the timing inputs. It walks the async or sync phase sequence and captures
// read words. Each captured word gives one registered response.
// Assumes cyc_last comes from a divider restarted at each sync access.
module mnb_fsm
    import mnb_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int DATA_W = 16,
    parameter int BANK_W = 2,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_sync,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [LEN_W-1:0]  req_len,
    input  mnb_timing_t       cfg,
    input  logic              wait_n,
    input  logic [DATA_W-1:0] ad_i,
    input  logic              cyc_last,
    output mnb_state_e        state,
    output logic              req_ready,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [BANK_W-1:0] bank_q,
    output logic              write_q,
    output mnb_timing_t       tim_q,
    output logic              rsp_valid,
    output logic              rsp_last,
    output logic [DATA_W-1:0] rsp_data
);
    logic [CFG_W-1:0] cnt;
    logic [LEN_W-1:0] words;

    assign req_ready = (state == ST_IDLE);

    // Phase sequencing, request latching and word capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            words     <= '0;
            addr_q    <= '0;
            wdata_q   <= '0;
            bank_q    <= '0;
            write_q   <= 1'b0;
            tim_q     <= '0;
            rsp_valid <= 1'b0;
            rsp_last  <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_last  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        bank_q  <= req_bank;
                        write_q <= req_write;
                        tim_q   <= cfg;
                        words   <= req_len;
                        if (req_sync && !req_write) begin
                            state <= ST_SADDR;
                        end else begin
                            state <= ST_AADDR;
                            cnt   <= cfg.aset;
                        end
                    end
                end
                ST_AADDR: begin
                    if (cnt == '0) begin
                        state <= ST_ADATA;
                        cnt   <= tim_q.dset;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_ADATA: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (wait_n) begin
                        rsp_valid <= 1'b1;
                        rsp_last  <= 1'b1;
                        rsp_data  <= write_q ? '0 : ad_i;
                        state     <= ST_TURN;
                        cnt       <= tim_q.turn;
                    end
                end
                ST_SADDR: begin
                    if (cyc_last) begin
                        state <= ST_SLAT;
                        cnt   <= tim_q.lat;
                    end
                end
                ST_SLAT: begin
                    if (cyc_last) begin
                        if (cnt == '0) begin
                            state <= ST_SDATA;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                end
                ST_SDATA: begin
                    if (cyc_last && wait_n) begin
                        rsp_valid <= 1'b1;
                        rsp_data  <= ad_i;
                        if (words == '0) begin
                            rsp_last <= 1'b1;
                            state    <= ST_TURN;
                            cnt      <= tim_q.turn;
                        end else begin
                            words <= words - 1'b1;
                        end
                    end
                end
                ST_TURN: begin
                    if (cnt == '0) begin
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    a_r8_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last |-> rsp_valid);
    a_r4_no_capture_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(wait_n));
    a_r10_timing_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(tim_q));
endmodule

// File: rtl/mnb_pins.sv
// Pin decoder. Turns the sequencer state and latched request into the
// active-low strobes, one chip select per bank, and the shared bus drive.
// Assumes the state and request fields come straight from flops.
module mnb_pins
    import mnb_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BANKS  = 4,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mnb_state_e        state,
    input  logic              write_q,
    input  logic [BANK_W-1:0] bank_q,
    input  logic [DATA_W-1:0] addr_lo,
    input  logic [DATA_W-1:0] wdata_q,
    output logic [BANKS-1:0]  ce_n,
    output logic              oe_n,
    output logic              we_n,
    output logic              adv_n,
    output logic [DATA_W-1:0] ad_o,
    output logic              ad_oe
);
    logic sel_phase;
    logic adr_phase;
    logic dat_phase;

    // Phase classification shared by all strobes.
    always_comb begin
        adr_phase = (state == ST_AADDR) || (state == ST_SADDR);
        dat_phase = (state == ST_ADATA) || (state == ST_SLAT) || (state == ST_SDATA);
        sel_phase = adr_phase || dat_phase;
    end

    // One chip select per bank, low only for the latched bank.
    for (genvar b = 0; b < BANKS; b++) begin : g_ce
        assign ce_n[b] = !(sel_phase && (bank_q == BANK_W'(b)));
    end

    // Strobes and shared bus drive.
    always_comb begin
        adv_n = !adr_phase;
        oe_n  = !(dat_phase && !write_q);
        we_n  = !(dat_phase && write_q);
        ad_oe = adr_phase || (dat_phase && write_q);
        if (adr_phase) begin
            ad_o = addr_lo;
        end else if (dat_phase && write_q) begin
            ad_o = wdata_q;
        end else begin
            ad_o = '0;
        end
    end

    a_r3_oe_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));
    a_r5_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ce_n));
    a_r2_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !ad_oe);
    a_r3_drive_gated: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> (!adv_n || !we_n));
endmodule

// File: rtl/mnb_ctrl.sv
// Multiplexed NOR/PSRAM bus controller top. Joins the sequencer, the memory
// clock divider and the pin decoder. Presents the shared bus as separate
// out/enable/in vectors for an external pad.
// Assumes the timing inputs are settled when a request is accepted.
module mnb_ctrl
    import mnb_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int DATA_W = 16,
    parameter int BANKS  = 4,
    parameter int LEN_W  = 4,
    localparam int BANK_W = $clog2(BANKS),
    localparam int HI_W   = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_sync,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [CFG_W-1:0]  cfg_div,
    input  logic [CFG_W-1:0]  cfg_lat,
    input  logic [CFG_W-1:0]  cfg_turn,
    input  logic [CFG_W-1:0]  cfg_aset,
    input  logic [CFG_W-1:0]  cfg_dset,
    output logic              rsp_valid,
    output logic              rsp_last,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_clk,
    output logic [BANKS-1:0]  mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_adv_n,
    output logic [HI_W-1:0]   mem_addr_hi,
    output logic [DATA_W-1:0] mem_ad_o,
    output logic              mem_ad_oe,
    input  logic [DATA_W-1:0] mem_ad_i,
    input  logic              mem_wait_n
);
    mnb_timing_t       cfg;
    mnb_timing_t       tim_q;
    mnb_state_e        state;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [BANK_W-1:0] bank_q;
    logic              write_q;
    logic              run;
    logic              cyc_last;
    logic [CFG_W-1:0]  period_m1;

    // Timing inputs gathered for latching; divide ratio clamped to two.
    always_comb begin
        cfg.div   = cfg_div;
        cfg.lat   = cfg_lat;
        cfg.turn  = cfg_turn;
        cfg.aset  = cfg_aset;
        cfg.dset  = cfg_dset;
        period_m1 = (tim_q.div == '0) ? CFG_W'(1) : tim_q.div;
        run       = (state == ST_SADDR) || (state == ST_SLAT) || (state == ST_SDATA);
    end

    assign mem_addr_hi = addr_q[ADDR_W-1:DATA_W];

    mnb_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W), .LEN_W(LEN_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_sync  (req_sync),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_bank  (req_bank),
        .req_len   (req_len),
        .cfg       (cfg),
        .wait_n    (mem_wait_n),
        .ad_i      (mem_ad_i),
        .cyc_last  (cyc_last),
        .state     (state),
        .req_ready (req_ready),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .bank_q    (bank_q),
        .write_q   (write_q),
        .tim_q     (tim_q),
        .rsp_valid (rsp_valid),
        .rsp_last  (rsp_last),
        .rsp_data  (rsp_data)
    );

    mnb_mclk #(.CW(CFG_W)) u_mclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .period_m1 (period_m1),
        .mclk      (mem_clk),
        .cyc_last  (cyc_last)
    );

    mnb_pins #(
        .DATA_W(DATA_W), .BANKS(BANKS), .BANK_W(BANK_W)
    ) u_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .state   (state),
        .write_q (write_q),
        .bank_q  (bank_q),
        .addr_lo (addr_q[DATA_W-1:0]),
        .wdata_q (wdata_q),
        .ce_n    (mem_ce_n),
        .oe_n    (mem_oe_n),
        .we_n    (mem_we_n),
        .adv_n   (mem_adv_n),
        .ad_o    (mem_ad_o),
        .ad_oe   (mem_ad_oe)
    );

    a_r12_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (&mem_ce_n && !mem_clk));
endmodule

// File: tb/mnb_ctrl_test.sv
// Self-checking bench: sweeps small timing settings. The bus input carries
// BASE + cycle index, so a captured word reveals its sampling cycle.
module mnb_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] BASE = 16'hA000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_sync = 1'b0;
    logic [25:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_bank = '0;
    logic [3:0]  req_len = '0;
    logic [3:0]  cfg_div = '0, cfg_lat = '0, cfg_turn = '0, cfg_aset = '0, cfg_dset = '0;
    logic        rsp_valid, rsp_last;
    logic [15:0] rsp_data;
    logic        mem_clk;
    logic [3:0]  mem_ce_n;
    logic        mem_oe_n, mem_we_n, mem_adv_n;
    logic [9:0]  mem_addr_hi;
    logic [15:0] mem_ad_o;
    logic        mem_ad_oe;
    logic [15:0] mem_ad_i = '0;
    logic        mem_wait_n = 1'b1;

    int total = 0;
    int bad = 0;

    mnb_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_sync(req_sync), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_bank(req_bank), .req_len(req_len),
        .cfg_div(cfg_div), .cfg_lat(cfg_lat), .cfg_turn(cfg_turn),
        .cfg_aset(cfg_aset), .cfg_dset(cfg_dset), .rsp_valid(rsp_valid),
        .rsp_last(rsp_last), .rsp_data(rsp_data), .mem_clk(mem_clk),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_adv_n(mem_adv_n), .mem_addr_hi(mem_addr_hi), .mem_ad_o(mem_ad_o),
        .mem_ad_oe(mem_ad_oe), .mem_ad_i(mem_ad_i), .mem_wait_n(mem_wait_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One access: compute expected capture cycles, then compare every cycle.
    task automatic run(input bit wr, input bit sy, input logic [25:0] a,
                       input logic [15:0] wd, input int bk, input int ln,
                       input int dv, input int lt, input int tu, input int as,
                       input int ds, input int ws, input int we,
                       input bit scramble, input bit poke, input string ctx);
        bit eff_sync = sy && !wr;
        int p   = (dv == 0) ? 2 : dv + 1;
        int l   = lt + 2;
        int t   = tu + 1;
        int aph_len = eff_sync ? p : as + 1;
        int n   = eff_sync ? ln + 1 : 1;
        int cap[16];
        int clast, endi, c, k, m;
        int e_pin = 0, e_drv = 0, e_ce = 0, e_clk = 0, e_rdy = 0, e_rsp = 0, got = 0;
        if (!eff_sync) begin
            c = as + 1 + ds;
            while (c >= ws && c <= we) c++;
            cap[0] = c;
        end else begin
            k = 0;
            m = l;
            while (k < n) begin
                c = m * p + p - 1;
                if (!(c >= ws && c <= we)) begin
                    cap[k] = c;
                    k++;
                end
                m++;
            end
        end
        clast = cap[n-1];
        endi  = clast + t + 1;
        @(negedge clk);
        cfg_div = 4'(dv); cfg_lat = 4'(lt); cfg_turn = 4'(tu);
        cfg_aset = 4'(as); cfg_dset = 4'(ds);
        req_write = wr; req_sync = sy; req_addr = a; req_wdata = wd;
        req_bank = 2'(bk); req_len = 4'(ln); req_valid = 1'b1;
        mem_ad_i = BASE; mem_wait_n = 1'b1;
        @(posedge clk);
        for (int i = 0; i <= endi; i++) begin
            bit active, aph, hit, hit_last;
            int hit_data;
            logic [3:0] ce_exp;
            @(negedge clk);
            mem_ad_i   = 16'(BASE + 16'(i));
            mem_wait_n = !(i >= ws && i <= we);
            if (i == 0 && scramble) begin
                cfg_div = ~cfg_div; cfg_lat = ~cfg_lat; cfg_turn = ~cfg_turn;
                cfg_aset = ~cfg_aset; cfg_dset = ~cfg_dset;
            end
            req_valid = poke && (i < endi);
            if (poke) begin
                req_addr = a ^ 26'h155AA; req_bank = 2'(bk + 1); req_write = !wr;
            end
            active = (i <= clast);
            aph    = active && (i < aph_len);
            ce_exp = active ? ~(4'(1) << bk) : 4'hF;
            if (mem_ce_n !== ce_exp) e_ce++;
            if (mem_adv_n !== !aph) e_pin++;
            if (mem_oe_n !== !(active && !aph && !wr)) e_pin++;
            if (mem_we_n !== !(active && !aph && wr)) e_pin++;
            if (mem_ad_oe !== (aph || (active && wr))) e_drv++;
            if (aph && mem_ad_o !== a[15:0]) e_drv++;
            if (active && !aph && wr && mem_ad_o !== wd) e_drv++;
            if (active && mem_addr_hi !== a[25:16]) e_drv++;
            if (mem_clk !== (eff_sync && active && ((i % p) < p / 2))) e_clk++;
            if (req_ready !== (i == endi)) e_rdy++;
            hit = 0; hit_last = 0; hit_data = 0;
            for (int j = 0; j < n; j++) begin
                if (cap[j] + 1 == i) begin
                    hit = 1;
                    hit_last = (j == n - 1);
                    hit_data = wr ? 0 : int'(16'(BASE + 16'(cap[j])));
                end
            end
            if (rsp_valid !== hit) e_rsp++;
            if (hit) begin
                got++;
                if (rsp_data !== 16'(hit_data) || rsp_last !== hit_last) e_rsp++;
            end
        end
        check(e_ce == 0, {"R5 select ", ctx}, e_ce, 0);
        check(e_pin == 0, {wr ? "R3" : "R2", " strobes ", ctx}, e_pin, 0);
        check(e_drv == 0, {wr ? "R3" : "R2", " bus drive ", ctx}, e_drv, 0);
        check(e_clk == 0, {"R6 memory clock ", ctx}, e_clk, 0);
        check(e_rdy == 0, {"R9 turnaround ", ctx}, e_rdy, 0);
        check(e_rsp == 0, {"R7 capture timing/data ", ctx}, e_rsp, 0);
        check(got == n, {"R8 word count ", ctx}, got, n);
        req_valid = 1'b0;
        @(negedge clk);
        check(req_ready && mem_ce_n == 4'hF && !rsp_valid, {"R12 idle after ", ctx},
              int'(mem_ce_n), 4'hF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state.
        check(req_ready === 1'b1, "R1 ready", int'(req_ready), 1);
        check(mem_ce_n === 4'hF, "R1 selects", int'(mem_ce_n), 4'hF);
        check({mem_oe_n, mem_we_n, mem_adv_n} === 3'b111, "R1 strobes",
              int'({mem_oe_n, mem_we_n, mem_adv_n}), 7);
        check({mem_ad_oe, mem_clk, rsp_valid} === 3'b000, "R1 bus/clock/rsp",
              int'({mem_ad_oe, mem_clk, rsp_valid}), 0);

        for (int as = 0; as < 4; as++)
            for (int ds = 0; ds < 4; ds++)
                for (int tu = 0; tu < 4; tu += 3)
                    run(0, 0, 26'(26'h2A5C3 + as * 16 + ds), 16'h0, (as + ds) % 4, 0,
                        0, 0, tu, as, ds, -1, -1, 0, 0, "R2 async read");
        for (int as = 0; as < 3; as++)
            for (int ds = 0; ds < 3; ds++)
                run(1, 0, 26'(26'h3F00F + ds), 16'(16'h5A00 + as * 4 + ds), as, 0,
                    0, 0, 1, as, ds, -1, -1, 0, 0, "R3 async write");
        for (int ds = 0; ds < 3; ds++)
            run(0, 0, 26'h1234, 16'h0, 1, 0, 0, 0, 0, 1, ds, 2 + ds, 4 + ds, 0, 0,
                "R4 async wait");
        for (int dv = 0; dv < 5; dv++)
            for (int lt = 0; lt < 4; lt++)
                for (int ln = 0; ln < 3; ln += 2)
                    run(0, 1, 26'(26'h1F0A0 + dv * 8 + lt), 16'h0, lt, ln,
                        dv, lt, 1, 0, 0, -1, -1, 0, 0, "R7 sync burst");
        for (int ln = 0; ln < 16; ln++)
            run(0, 1, 26'(26'h3C000 + ln), 16'h0, 2, ln, 1, 0, 0, 0, 0, -1, -1, 0, 0,
                "R8 burst length");
        run(0, 1, 26'h0BEEF, 16'h0, 3, 3, 2, 1, 0, 0, 0, 9, 14, 0, 0, "R4 sync wait");
        run(0, 1, 26'h0BEEF, 16'h0, 0, 2, 3, 0, 2, 0, 0, 7, 7, 0, 0, "R4 sync wait single");
        for (int tu = 0; tu < 16; tu++)
            run(0, 0, 26'h00777, 16'h0, 0, 0, 0, 0, tu, 0, 1, -1, -1, 0, 0, "R9 turn sweep");
        run(0, 0, 26'h11111, 16'h0, 2, 0, 0, 0, 2, 2, 3, -1, -1, 1, 0, "R10 async sampled");
        run(0, 1, 26'h22222, 16'h0, 1, 2, 2, 1, 1, 0, 0, -1, -1, 1, 0, "R10 sync sampled");
        run(1, 1, 26'h33333, 16'hC3C3, 0, 5, 4, 3, 0, 1, 2, -1, -1, 0, 0, "R11 sync write");
        run(0, 0, 26'h04444, 16'h0, 1, 0, 0, 0, 2, 1, 1, -1, -1, 0, 1, "R12 held while busy");
        run(0, 1, 26'h05555, 16'h0, 2, 1, 1, 0, 1, 0, 0, -1, -1, 0, 1, "R12 held during burst");
        for (int bk = 0; bk < 4; bk++)
            run(0, 0, 26'(26'h06000 + bk), 16'h0, bk, 0, 0, 0, 0, 0, 0, -1, -1, 0, 0,
                "R5 bank sweep");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule